// File: doc/BRIEF.md
# Parity-Checked Read Path with Clean-Line Recovery

This block sits between the low-voltage (error-prone) ways of one cache set and the core that reads them. Every word written into these ways gets an even-parity bit. Every read recomputes that parity. The contents of these ways are always clean, which means the next memory level holds the same data. A parity error is therefore never fixed in place. The block either takes the data from the twin copy of the line or asks the next level for it again.

Pairing mode is controlled by one input. When it is on, ways form fixed pairs (0 with 1, 2 with 3, and so on), and every write lands in both ways of the pair. A read that finds a bad word in the addressed way returns the partner's word if the partner's parity is good. In every other error case, the block raises a refetch request and holds it until the lower level acknowledges. It then hands the returned word to the reader and rewrites the failing storage with fresh parity.

The array itself lives outside the block. The block sees the selected set's words and parity bits, and it drives a write-enable mask, a write word and a parity bit back to the array.

Top module: `nrc_recover_path`

## Requirements
- R1: Every array write carries a parity bit that makes the word plus that bit hold an even count of ones (`arr_wpar` = XOR of all bits of `arr_wdata`).
- R2: A read (`rd_req` high while `refetch_req` is low) of a way whose stored parity matches returns that way's word on `rd_data`, with `rd_valid` high for exactly one cycle, one clock after the request.
- R3: A read that needs a refetch raises `refetch_req` one clock after the request and reports the failing way on `refetch_way`. `refetch_req` stays high until the clock on which `refetch_ack` is seen, and `rd_valid` stays low for that whole time.
- R4: One clock after the acknowledge, `rd_valid` is high for one cycle with `rd_data` equal to the `refetch_data` that accompanied the acknowledge, and `refetch_req` is low.
- R5: On that same cycle, the write mask selects the failing way and the array write carries the refetched word with fresh parity.
- R6: With `dup_en` high, a write to way w drives a write mask with bits w and w XOR 1 set. Bit i of `arr_we` enables way i.
- R7: With `dup_en` high, a read whose way fails parity while its partner (way XOR 1) passes returns the partner's word one clock later, with no refetch.
- R8: With `dup_en` high and both ways of the pair failing, the block refetches, and the repair write mask covers both ways of the pair.
- R9: While `refetch_req` is high, `rd_req` and `wr_req` are ignored. They produce no `rd_valid` and no array write.
- R10: When `rd_req` and `wr_req` are both accepted in the same cycle, the read is served and the write is dropped, so no array write follows.
- R11: With `dup_en` low, a write enables only the addressed way, and a read error never uses the partner. It always refetches.
- R12: After reset, `rd_valid`, `refetch_req` and `arr_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dup_en | input | 1 | Pairing mode enable |
| rd_req | input | 1 | Read request |
| rd_way | input | WAY_W | Way to read |
| wr_req | input | 1 | Write request |
| wr_way | input | WAY_W | Way to write |
| wr_data | input | DATA_W | Word to write |
| line_data | input | WAYS*DATA_W | Stored words of the selected set, way i at bits i*DATA_W upward |
| line_par | input | WAYS | Stored parity bits, one per way |
| arr_we | output | WAYS | Array write-enable mask |
| arr_wdata | output | DATA_W | Array write word |
| arr_wpar | output | 1 | Array write parity |
| refetch_req | output | 1 | Refetch request to the next level; also marks the block busy |
| refetch_way | output | WAY_W | Way whose line is being refetched |
| refetch_ack | input | 1 | Next level returns the line |
| refetch_data | input | DATA_W | Returned line word |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read result |

## Verification
The properties assume that the next level acknowledges only while a refetch is pending. They also assume that `line_data` and `line_par` reflect the array contents in the cycle a read is issued. The bench keeps to both assumptions. It pulses `refetch_ack` only after observing `refetch_req`, and it models the array as registers written from `arr_we` and read back in the same cycle. Parity faults are injected by flipping a stored bit between operations. Each operation waits until the repair or the duplicate write has reached the array before the next one reads it.

// File: rtl/nrc_pkg.sv
package nrc_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } rc_state_e;
endpackage

// File: rtl/nrc_par_bank.sv
module nrc_par_bank #(
  parameter int WAYS   = 4,
  parameter int DATA_W = 32
) (
  input  logic [WAYS*DATA_W-1:0] line_data,
  input  logic [WAYS-1:0]        line_par,
  output logic [DATA_W-1:0]      lines [WAYS],
  output logic [WAYS-1:0]        bad
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign lines[g] = line_data[g*DATA_W +: DATA_W];
    // even parity: word plus stored bit must hold an even number of ones
    assign bad[g]   = (^line_data[g*DATA_W +: DATA_W]) ^ line_par[g];
  end
endmodule

// File: rtl/nrc_wr_mask.sv
module nrc_wr_mask #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAY_W-1:0] way,
  input  logic             pair,
  output logic [WAYS-1:0]  mask
);
  localparam logic [WAY_W-1:0] TWIN = WAY_W'(1);
  for (genvar g = 0; g < WAYS; g++) begin : g_bit
    assign mask[g] = (WAY_W'(g) == way) || (pair && (WAY_W'(g) == (way ^ TWIN)));
  end
endmodule

// File: rtl/nrc_recover_path.sv
module nrc_recover_path #(
  parameter int WAYS   = 4,
  parameter int DATA_W = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dup_en,
  input  logic                   rd_req,
  input  logic [WAY_W-1:0]       rd_way,
  input  logic                   wr_req,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [WAYS*DATA_W-1:0] line_data,
  input  logic [WAYS-1:0]        line_par,
  output logic [WAYS-1:0]        arr_we,
  output logic [DATA_W-1:0]      arr_wdata,
  output logic                   arr_wpar,
  output logic                   refetch_req,
  output logic [WAY_W-1:0]       refetch_way,
  input  logic                   refetch_ack,
  input  logic [DATA_W-1:0]      refetch_data,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data
);
  import nrc_pkg::*;

  localparam logic [WAY_W-1:0] TWIN = WAY_W'(1);

  rc_state_e         state_q;
  logic [WAY_W-1:0]  fail_way_q;
  logic              fix_pair_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [WAYS-1:0]   we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wpar_q;

  logic [DATA_W-1:0] lines [WAYS];
  logic [WAYS-1:0]   bad;

  nrc_par_bank #(.WAYS(WAYS), .DATA_W(DATA_W)) u_par (
    .line_data (line_data),
    .line_par  (line_par),
    .lines     (lines),
    .bad       (bad)
  );

  logic             busy, rd_fire, wr_fire, fetch_done;
  logic [WAY_W-1:0] twin_way;
  logic             self_bad, twin_bad, use_twin, need_fetch;

  assign busy       = (state_q == ST_FETCH);
  assign rd_fire    = rd_req && !busy;
  assign wr_fire    = wr_req && !busy && !rd_fire;
  assign fetch_done = busy && refetch_ack;
  assign twin_way   = rd_way ^ TWIN;
  assign self_bad   = bad[rd_way];
  assign twin_bad   = bad[twin_way];
  assign use_twin   = dup_en && self_bad && !twin_bad;
  assign need_fetch = self_bad && !use_twin;

  // one mask generator serves host writes and repair writes
  logic [WAY_W-1:0] mask_way;
  logic             mask_pair;
  logic [WAYS-1:0]  mask;

  assign mask_way  = fetch_done ? fail_way_q : wr_way;
  assign mask_pair = fetch_done ? fix_pair_q : dup_en;

  nrc_wr_mask #(.WAYS(WAYS), .WAY_W(WAY_W)) u_mask (
    .way  (mask_way),
    .pair (mask_pair),
    .mask (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      fail_way_q <= '0;
      fix_pair_q <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      we_q       <= '0;
      wdata_q    <= '0;
      wpar_q     <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      we_q       <= '0;
      case (state_q)
        ST_IDLE: begin
          if (rd_fire) begin
            if (need_fetch) begin
              state_q    <= ST_FETCH;
              fail_way_q <= rd_way;
              fix_pair_q <= dup_en && twin_bad;
            end else begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= use_twin ? lines[twin_way] : lines[rd_way];
            end
          end else if (wr_fire) begin
            we_q    <= mask;
            wdata_q <= wr_data;
            wpar_q  <= ^wr_data;
          end
        end
        ST_FETCH: begin
          if (refetch_ack) begin
            state_q    <= ST_IDLE;
            rd_valid_q <= 1'b1;
            rd_data_q  <= refetch_data;
            we_q       <= mask;
            wdata_q    <= refetch_data;
            wpar_q     <= ^refetch_data;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arr_we      = we_q;
  assign arr_wdata   = wdata_q;
  assign arr_wpar    = wpar_q;
  assign refetch_req = busy;
  assign refetch_way = fail_way_q;
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
endmodule

// File: rtl/nrc_recover_sva.sv
module nrc_recover_sva #(
  parameter int WAYS   = 4,
  parameter int DATA_W = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic [WAYS-1:0]   arr_we,
  input logic [DATA_W-1:0] arr_wdata,
  input logic              arr_wpar,
  input logic              refetch_req,
  input logic [WAY_W-1:0]  refetch_way,
  input logic              refetch_ack,
  input logic [DATA_W-1:0] refetch_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  AST_WR_PAR_EVEN: assert property (@(posedge clk) disable iff (rst)
    (|arr_we) |-> ((^{arr_wdata, arr_wpar}) == 1'b0)); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (refetch_req && !refetch_ack) |=> refetch_req); // R3
  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (rst)
    refetch_req |-> !rd_valid); // R3
  AST_REQ_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(refetch_req) |-> $past(rd_req)); // R3
  AST_ACK_RETURN: assert property (@(posedge clk) disable iff (rst)
    (refetch_req && refetch_ack) |=> (rd_valid && !refetch_req && rd_data == $past(refetch_data))); // R4
  AST_REPAIR_WR: assert property (@(posedge clk) disable iff (rst)
    (refetch_req && refetch_ack) |=> (arr_we[$past(refetch_way)] && arr_wdata == $past(refetch_data))); // R5
  AST_MASK_SPAN: assert property (@(posedge clk) disable iff (rst)
    $countones(arr_we) <= 2); // R6
  AST_NO_WR_WAIT: assert property (@(posedge clk) disable iff (rst)
    refetch_req |-> (arr_we == '0)); // R9
endmodule

bind nrc_recover_path nrc_recover_sva #(.WAYS(WAYS), .DATA_W(DATA_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .rd_req       (rd_req),
  .arr_we       (arr_we),
  .arr_wdata    (arr_wdata),
  .arr_wpar     (arr_wpar),
  .refetch_req  (refetch_req),
  .refetch_way  (refetch_way),
  .refetch_ack  (refetch_ack),
  .refetch_data (refetch_data),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data)
);

// File: tb/nrc_recover_path_tb.sv
module nrc_recover_path_tb_top;
  localparam int WAYS   = 4;
  localparam int DATA_W = 32;
  localparam int WAY_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic                   dup_en = 0, rd_req = 0, wr_req = 0, refetch_ack = 0;
  logic [WAY_W-1:0]       rd_way = 0, wr_way = 0;
  logic [DATA_W-1:0]      wr_data = 0, refetch_data = 0;
  logic [WAYS*DATA_W-1:0] line_data;
  logic [WAYS-1:0]        line_par;
  logic [WAYS-1:0]        arr_we;
  logic [DATA_W-1:0]      arr_wdata, rd_data;
  logic                   arr_wpar, refetch_req, rd_valid;
  logic [WAY_W-1:0]       refetch_way;

  nrc_recover_path #(.WAYS(WAYS), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .dup_en(dup_en), .rd_req(rd_req), .rd_way(rd_way),
    .wr_req(wr_req), .wr_way(wr_way), .wr_data(wr_data),
    .line_data(line_data), .line_par(line_par),
    .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_wpar(arr_wpar),
    .refetch_req(refetch_req), .refetch_way(refetch_way),
    .refetch_ack(refetch_ack), .refetch_data(refetch_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // array model plus fault injection
  logic [DATA_W-1:0] mem [WAYS];
  logic [WAYS-1:0]   par;
  logic              inj_en = 0;
  logic [WAY_W-1:0]  inj_way = 0;
  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) begin mem[w] <= '0; par[w] <= 1'b0; end
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (arr_we[w]) begin mem[w] <= arr_wdata; par[w] <= arr_wpar; end
      if (inj_en) mem[inj_way][0] <= ~mem[inj_way][0];
    end
  end
  always_comb begin
    for (int w = 0; w < WAYS; w++) line_data[w*DATA_W +: DATA_W] = mem[w];
    line_par = par;
  end

  // reference: true line values held by the next level
  logic [DATA_W-1:0] backing [WAYS];
  initial for (int w = 0; w < WAYS; w++) backing[w] = '0;

  int total = 0, bad = 0, cyc = 0;
  logic exp_valid = 0, exp_req = 0, mon_on = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // per-clock comparison against the model's expected strobes
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      chk(rd_valid === exp_valid, "R4", "rd_valid per cycle", 64'(rd_valid), 64'(exp_valid));
      chk(refetch_req === exp_req, "R3", "refetch_req per cycle", 64'(refetch_req), 64'(exp_req));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_write(input int way, input logic [DATA_W-1:0] d, input bit dup,
                          input logic [WAYS-1:0] xmask, input string tag);
    @(negedge clk);
    wr_req = 1; wr_way = WAY_W'(way); wr_data = d; dup_en = dup;
    @(negedge clk);
    wr_req = 0;
    chk(arr_we === xmask, tag, "write mask", 64'(arr_we), 64'(xmask));
    chk(arr_wdata === d, tag, "write word", 64'(arr_wdata), 64'(d));
    chk(arr_wpar === ^d, "R1", "write parity", 64'(arr_wpar), 64'(^d));
    for (int w = 0; w < WAYS; w++) if (xmask[w]) backing[w] = d;
    @(negedge clk);
  endtask

  task automatic corrupt(input int way);
    @(negedge clk);
    inj_en = 1; inj_way = WAY_W'(way);
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic read_direct(input int way, input bit dup, input logic [DATA_W-1:0] xd,
                             input string tag);
    @(negedge clk);
    rd_req = 1; rd_way = WAY_W'(way); dup_en = dup;
    @(negedge clk);
    rd_req = 0; exp_valid = 1;
    #1;
    chk(rd_data === xd, tag, "read word", 64'(rd_data), 64'(xd));
    @(negedge clk);
    exp_valid = 0;
  endtask

  task automatic read_fetch(input int way, input bit dup, input logic [WAYS-1:0] xmask,
                            input string tag);
    logic [DATA_W-1:0] xd;
    xd = backing[way];
    @(negedge clk);
    rd_req = 1; rd_way = WAY_W'(way); dup_en = dup;
    @(negedge clk);
    rd_req = 0; exp_req = 1;
    chk(refetch_way === WAY_W'(way), "R3", "refetch way", 64'(refetch_way), 64'(way));
    // R9: read and write poked while waiting must be ignored
    rd_req = 1; rd_way = WAY_W'(way ^ 1); wr_req = 1; wr_way = WAY_W'(way); wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    chk(arr_we === '0, "R9", "no write while waiting", 64'(arr_we), 64'(0));
    @(negedge clk);
    chk(arr_we === '0, "R9", "no write while waiting", 64'(arr_we), 64'(0));
    refetch_ack = 1; refetch_data = xd;
    @(negedge clk);
    refetch_ack = 0; exp_req = 0; exp_valid = 1;
    #1;
    chk(rd_data === xd, "R4", "refetched word", 64'(rd_data), 64'(xd));
    chk(arr_we === xmask, tag, "repair mask", 64'(arr_we), 64'(xmask));
    chk(arr_wdata === xd, "R5", "repair word", 64'(arr_wdata), 64'(xd));
    chk(arr_wpar === ^xd, "R5", "repair parity", 64'(arr_wpar), 64'(^xd));
    @(negedge clk);
    exp_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rd_valid === 0 && refetch_req === 0 && arr_we === '0, "R12", "reset outputs",
        {61'(0), rd_valid, refetch_req, |arr_we}, 64'(0));
    mon_on = 1;

    do_write(0, 32'h1234_5678, 0, 4'b0001, "R11");
    do_write(1, 32'h0000_0007, 0, 4'b0010, "R11");
    read_direct(0, 0, 32'h1234_5678, "R2");
    read_direct(1, 0, 32'h0000_0007, "R2");
    do_write(2, 32'hA5A5_0F01, 1, 4'b1100, "R6");
    read_direct(3, 1, 32'hA5A5_0F01, "R6");
    corrupt(2);
    read_direct(2, 1, 32'hA5A5_0F01, "R7");
    corrupt(0);
    read_fetch(0, 0, 4'b0001, "R11");
    read_direct(0, 0, 32'h1234_5678, "R5");
    corrupt(3);
    read_fetch(3, 1, 4'b1100, "R8");
    read_direct(2, 1, 32'hA5A5_0F01, "R8");
    read_direct(3, 0, 32'hA5A5_0F01, "R8");

    // R10: read and write in the same cycle, write dropped
    @(negedge clk);
    rd_req = 1; rd_way = 2'd3; wr_req = 1; wr_way = 2'd1; wr_data = 32'h5555_AAAA; dup_en = 0;
    @(negedge clk);
    rd_req = 0; wr_req = 0; exp_valid = 1;
    #1;
    chk(rd_data === 32'hA5A5_0F01, "R10", "read served", 64'(rd_data), 64'h A5A5_0F01);
    chk(arr_we === '0, "R10", "write dropped", 64'(arr_we), 64'(0));
    @(negedge clk);
    exp_valid = 0;
    chk(arr_we === '0, "R10", "write dropped later", 64'(arr_we), 64'(0));
    read_direct(1, 0, 32'h0000_0007, "R10");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule